// File: doc/BRIEF.md
# Serial Flash Power-Down and Signature Responder

This block is the slave-side control for the low-power state of a serial flash device. It watches an SPI mode 0 bit stream made of an active-low select, a serial clock and a serial data input. All three are synchronised into the system clock domain. The block recognises two single-byte commands. One puts the device into deep power-down. The other releases the device and reads back its fixed 8-bit signature. The signature is driven on the serial output together with an output-enable that an I/O pad uses to tristate the line.

In deep power-down, every command except release is dropped. A release that arrives from deep power-down does not reach standby at once: a wake-up counter in system clock cycles runs first, and the ready output stays low until it expires. A selection that falls inside that window is ignored. A release that arrives from standby leaves the state untouched. An array-busy input from the program/erase controller makes the block ignore a release while such a cycle is running. The signature keeps repeating for as long as the host keeps clocking.

Top module: `pd_sig_responder`

## Requirements
- R1: After reset the block is in standby: ready is 1, in_pd is 0, so_oe is 0 and so is 0.
- R2: Opcode 0xB9, sent with exactly 8 rising SCK edges and followed by cs_n going high, moves the block from standby to deep power-down: in_pd becomes 1 and ready becomes 0.
- R3: A 0xB9 selection that ends after fewer or more than 8 rising SCK edges leaves the power state unchanged.
- R4: In deep power-down, any opcode other than 0xAB is ignored: so_oe stays 0 and in_pd stays 1.
- R5: Opcode 0xAB is followed by 24 dummy bits, and input bits are taken on rising SCK edges. so_oe stays 0 while cs_n is high and through the opcode and dummy bits. After that, the signature 0x12 is driven MSB first, with so updating only after a falling SCK edge.
- R6: While cs_n stays low and SCK keeps toggling, the signature repeats without a gap.
- R7: If busy is 1 when the 8th opcode bit is taken, 0xAB is ignored: no output is driven and the power state does not change.
- R8: When 0xAB was accepted in deep power-down, the rise of cs_n starts a wake-up interval of WAKE_CYCLES clocks. During it, ready and in_pd are both 0, and ready returns to 1 only after the interval. A 0xAB from standby leaves ready at 1 with no interval.
- R9: In deep power-down, a 0xAB selection that ends after the full opcode but before the signature still starts the wake-up interval. One that ends before the 8th bit does not.
- R10: A selection that begins during the wake-up interval is ignored in full, even if it is still in progress when the interval ends.
- R11: In standby, opcodes other than 0xAB and 0xB9 are ignored: so_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low (asynchronous) |
| sck | input | 1 | Serial clock, mode 0 (asynchronous) |
| si | input | 1 | Serial data in |
| busy | input | 1 | Program, erase or status-write cycle running |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so (0 means high impedance) |
| ready | output | 1 | Standby reached, commands accepted |
| in_pd | output | 1 | Deep power-down state |

## Verification
The bench builds the block with WAKE_CYCLES at 40 and two synchroniser stages, and holds each SCK phase for six system clocks. At 40 cycles the wake-up window is shorter than one command byte. This lets a selection that starts inside the window run past its end, and that case shows that the ignore decision is latched when the selection begins. The short window also keeps the cycle-exact comparison of ready and in_pd around the interval cheap. The two-stage synchroniser fixes an edge-to-output latency that the reference model reproduces clock for clock.

// File: rtl/pdsig_pkg.sv
package pdsig_pkg;
  typedef enum logic [1:0] {PW_STANDBY, PW_DEEP, PW_WAKE} pwr_t;
  typedef enum logic [1:0] {CM_IGNORE, CM_OPCODE, CM_SLEEP, CM_SIGNAL} cmd_t;
endpackage

// File: rtl/pdsig_sync.sv
module pdsig_sync #(
  parameter int STAGES = 2,
  parameter bit IDLE   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{IDLE}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/pdsig_edge.sv
module pdsig_edge #(
  parameter bit IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/pdsig_cmd.sv
module pdsig_cmd
  import pdsig_pkg::*;
#(
  parameter int          OPC_W       = 8,
  parameter int          DUMMY_BYTES = 3,
  parameter logic [7:0]  SLEEP_OP    = 8'hB9,
  parameter logic [7:0]  WAKE_OP     = 8'hAB
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_fall,
  input  logic cs_rise,
  input  logic sck_rise,
  input  logic sdi,
  input  logic busy,
  input  logic in_deep,
  input  logic waking,
  output logic sleep_go,
  output logic wake_go,
  output logic tx_en
);
  localparam int HDR = OPC_W * (1 + DUMMY_BYTES);
  localparam int CW  = $clog2(HDR + 1);

  cmd_t             mode, dec;
  logic [CW-1:0]    cnt;
  logic [OPC_W-2:0] shreg;
  logic [OPC_W-1:0] opc_now;

  assign opc_now = {shreg, sdi};

  always_comb begin
    if (opc_now == WAKE_OP[OPC_W-1:0] && !busy)       dec = CM_SIGNAL;
    else if (opc_now == SLEEP_OP[OPC_W-1:0] && !in_deep) dec = CM_SLEEP;
    else                                              dec = CM_IGNORE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= CM_IGNORE;
      cnt   <= '0;
      shreg <= '0;
    end else if (cs_fall) begin
      mode  <= waking ? CM_IGNORE : CM_OPCODE;
      cnt   <= '0;
    end else if (cs_rise) begin
      mode  <= CM_IGNORE;
    end else if (sck_rise && mode != CM_IGNORE) begin
      shreg <= opc_now[OPC_W-2:0];
      if (cnt != CW'(HDR)) cnt <= cnt + 1'b1;
      if (mode == CM_OPCODE && cnt == CW'(OPC_W - 1)) mode <= dec;
    end
  end

  assign sleep_go = cs_rise && mode == CM_SLEEP && cnt == CW'(OPC_W);
  assign wake_go  = cs_rise && mode == CM_SIGNAL && in_deep;
  assign tx_en    = mode == CM_SIGNAL && cnt == CW'(HDR);
endmodule

// File: rtl/pdsig_pwr.sv
module pdsig_pwr
  import pdsig_pkg::*;
#(
  parameter int WAKE_CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_go,
  input  logic wake_go,
  output pwr_t state,
  output logic ready,
  output logic in_deep,
  output logic waking
);
  localparam int TW = $clog2(WAKE_CYCLES + 1);

  logic [TW-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PW_STANDBY;
      wcnt  <= '0;
    end else begin
      case (state)
        PW_STANDBY: if (sleep_go) state <= PW_DEEP;
        PW_DEEP: if (wake_go) begin
          state <= PW_WAKE;
          wcnt  <= TW'(WAKE_CYCLES - 1);
        end
        PW_WAKE: begin
          if (wcnt == '0) state <= PW_STANDBY;
          else            wcnt  <= wcnt - 1'b1;
        end
        default: state <= PW_STANDBY;
      endcase
    end
  end

  assign ready   = state == PW_STANDBY;
  assign in_deep = state == PW_DEEP;
  assign waking  = state == PW_WAKE;
endmodule

// File: rtl/pdsig_tx.sv
module pdsig_tx #(
  parameter int         SIG_W = 8,
  parameter logic [7:0] SIG   = 8'h12
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_fall,
  input  logic cs_rise,
  input  logic sck_fall,
  input  logic tx_en,
  output logic so,
  output logic so_oe
);
  logic [SIG_W-1:0] rot;

  always_ff @(posedge clk) begin
    if (rst || cs_fall || cs_rise) begin
      rot   <= SIG[SIG_W-1:0];
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else if (sck_fall && tx_en) begin
      so    <= rot[SIG_W-1];
      so_oe <= 1'b1;
      rot   <= {rot[SIG_W-2:0], rot[SIG_W-1]};
    end
  end
endmodule

// File: rtl/pd_sig_responder.sv
module pd_sig_responder
  import pdsig_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         WAKE_CYCLES = 40,
  parameter int         DUMMY_BYTES = 3,
  parameter logic [7:0] SLEEP_OP    = 8'hB9,
  parameter logic [7:0] WAKE_OP     = 8'hAB,
  parameter logic [7:0] SIGNATURE   = 8'h12
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic busy,
  output logic so,
  output logic so_oe,
  output logic ready,
  output logic in_pd
);
  localparam int OPC_W = 8;

  logic cs_lvl, sck_lvl, si_lvl;
  logic cs_rise, cs_fall, sck_rise_raw, sck_fall_raw;
  logic sck_rise_g, sck_fall_g, sel;
  logic sleep_go, wake_go, tx_en, waking, in_deep;
  pwr_t pwr_st;

  pdsig_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_cs_sync
    (.clk(clk), .rst(rst), .din(cs_n), .lvl(cs_lvl));
  pdsig_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_sck_sync
    (.clk(clk), .rst(rst), .din(sck), .lvl(sck_lvl));
  pdsig_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_si_sync
    (.clk(clk), .rst(rst), .din(si), .lvl(si_lvl));

  pdsig_edge #(.IDLE(1'b1)) u_cs_edge
    (.clk(clk), .rst(rst), .lvl(cs_lvl), .rise(cs_rise), .fall(cs_fall));
  pdsig_edge #(.IDLE(1'b0)) u_sck_edge
    (.clk(clk), .rst(rst), .lvl(sck_lvl), .rise(sck_rise_raw), .fall(sck_fall_raw));

  assign sel        = ~cs_lvl;
  assign sck_rise_g = sck_rise_raw & sel;
  assign sck_fall_g = sck_fall_raw & sel;

  pdsig_cmd #(.OPC_W(OPC_W), .DUMMY_BYTES(DUMMY_BYTES),
              .SLEEP_OP(SLEEP_OP), .WAKE_OP(WAKE_OP)) u_cmd (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise_g), .sdi(si_lvl), .busy(busy),
    .in_deep(in_deep), .waking(waking),
    .sleep_go(sleep_go), .wake_go(wake_go), .tx_en(tx_en)
  );

  pdsig_pwr #(.WAKE_CYCLES(WAKE_CYCLES)) u_pwr (
    .clk(clk), .rst(rst), .sleep_go(sleep_go), .wake_go(wake_go),
    .state(pwr_st), .ready(ready), .in_deep(in_deep), .waking(waking)
  );

  pdsig_tx #(.SIG_W(OPC_W), .SIG(SIGNATURE)) u_tx (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_fall(sck_fall_g), .tx_en(tx_en), .so(so), .so_oe(so_oe)
  );

  assign in_pd = in_deep;
endmodule

// File: rtl/pdsig_checker.sv
module pdsig_checker
  import pdsig_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic so,
  input logic so_oe,
  input logic ready,
  input logic in_pd,
  input logic sck_fall,
  input pwr_t pwr
);
  // R2: deep power-down and ready are exclusive
  a_r2_deep_not_ready: assert property (@(posedge clk) disable iff (rst)
    in_pd |-> !ready);

  // R8: deep power-down never jumps straight to standby
  a_r8_no_direct_wake: assert property (@(posedge clk) disable iff (rst)
    (pwr == PW_DEEP) |=> (pwr != PW_STANDBY));

  // R8: ready only comes back through the wake-up interval
  a_r8_ready_after_wake: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(pwr) == PW_WAKE);

  // R5: output enable turns on only after a falling SCK edge
  a_r5_oe_on_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(so_oe) |-> $past(sck_fall));

  // R6: driven data changes only after a falling SCK edge
  a_r6_so_holds: assert property (@(posedge clk) disable iff (rst)
    (so_oe && $past(so_oe) && !$past(sck_fall)) |-> $stable(so));
endmodule

bind pd_sig_responder pdsig_checker u_chk (
  .clk(clk), .rst(rst), .so(so), .so_oe(so_oe), .ready(ready),
  .in_pd(in_pd), .sck_fall(sck_fall_g), .pwr(pwr_st)
);

// File: tb/pd_sig_responder_test.sv
module pd_sig_responder_test;
  localparam int TW    = 40;
  localparam int H     = 6;
  localparam int SIGV  = 8'h12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, busy = 1'b0;
  logic so, so_oe, ready, in_pd;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pd_sig_responder #(.SYNC_STAGES(2), .WAKE_CYCLES(TW)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .busy(busy),
    .so(so), .so_oe(so_oe), .ready(ready), .in_pd(in_pd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 standby, 1 deep, 2 waking; modes 0 ignore,1 opcode,2 sleep,3 signature
  int  m_st, m_wc, m_mode, m_bits, m_opc, m_idx;
  bit  m_oe, m_so;
  bit  c1, c2, cp, k1, k2, kp, s1, s2;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_wc = 0; m_mode = 0; m_bits = 0; m_opc = 0; m_idx = 0;
      m_oe = 0; m_so = 0;
      c1 = 1; c2 = 1; cp = 1; k1 = 0; k2 = 0; kp = 0; s1 = 0; s2 = 0;
    end else begin
      bit cr, cf, kr, kf, go_sleep, go_wake, sending;
      int nst, nwc;
      cr = c2 && !cp;  cf = !c2 && cp;
      kr = !c2 && k2 && !kp;  kf = !c2 && !k2 && kp;
      go_sleep = cr && m_mode == 2 && m_bits == 8;
      go_wake  = cr && m_mode == 3 && m_st == 1;
      sending  = m_mode == 3 && m_bits == 32;
      nst = m_st; nwc = m_wc;
      if (m_st == 0 && go_sleep) nst = 1;
      else if (m_st == 1 && go_wake) begin nst = 2; nwc = TW - 1; end
      else if (m_st == 2) begin
        if (m_wc == 0) nst = 0; else nwc = m_wc - 1;
      end
      if (cr || cf) begin m_oe = 0; m_so = 0; m_idx = 0; end
      else if (kf && sending) begin
        m_so = (SIGV >> (7 - m_idx)) & 1; m_oe = 1; m_idx = (m_idx + 1) % 8;
      end
      if (cf) begin
        m_mode = (m_st == 2) ? 0 : 1; m_bits = 0; m_opc = 0;
      end else if (cr) m_mode = 0;
      else if (kr && m_mode != 0) begin
        m_opc = ((m_opc << 1) | int'(s2)) & 255;
        if (m_bits == 7 && m_mode == 1) begin
          if (m_opc == 'hAB && !busy) m_mode = 3;
          else if (m_opc == 'hB9 && m_st != 1) m_mode = 2;
          else m_mode = 0;
        end
        if (m_bits < 32) m_bits++;
      end
      m_st = nst; m_wc = nwc;
      cp = c2; c2 = c1; c1 = cs_n;
      kp = k2; k2 = k1; k1 = sck;
      s2 = s1; s1 = si;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R8 model ready", int'(ready), int'(m_st == 0));
      chk("R2 model in_pd", int'(in_pd), int'(m_st == 1));
      chk("R5 model so_oe", int'(so_oe), int'(m_oe));
      chk("R6 model so", int'(so), int'(m_so));
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic select_dev();
    cs_n = 1'b0;
    wait_clk(H);
  endtask

  task automatic deselect_dev();
    wait_clk(H);
    cs_n = 1'b1;
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      si = tx[7-i];
      wait_clk(H);
      rx = {rx[6:0], so};
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
    end
  endtask

  task automatic header(input logic [7:0] opc);
    logic [7:0] r;
    xfer(opc, 8, r);
    for (int b = 0; b < 3; b++) begin
      xfer(8'h00, 8, r);
      chk("R5 oe low in dummy", int'(so_oe), 0);
    end
  endtask

  initial begin
    logic [7:0] r;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    chk("R1 ready", int'(ready), 1);
    chk("R1 in_pd", int'(in_pd), 0);
    chk("R1 so_oe", int'(so_oe), 0);
    chk("R1 so", int'(so), 0);

    // R11: unknown opcode in standby
    select_dev();
    xfer(8'h9F, 8, r);
    for (int b = 0; b < 4; b++) xfer(8'h00, 8, r);
    chk("R11 no output", int'(so_oe), 0);
    deselect_dev(); wait_clk(10);

    // R5/R6: signature from standby, repeated
    select_dev();
    chk("R5 oe low while opcode", int'(so_oe), 0);
    header(8'hAB);
    xfer(8'h00, 8, r); chk("R5 signature", int'(r), SIGV);
    chk("R5 oe high", int'(so_oe), 1);
    xfer(8'h00, 8, r); chk("R6 repeat 1", int'(r), SIGV);
    xfer(8'h00, 8, r); chk("R6 repeat 2", int'(r), SIGV);
    deselect_dev(); wait_clk(4);
    chk("R8 standby release immediate", int'(ready), 1);
    chk("R5 oe off after deselect", int'(so_oe), 0);
    wait_clk(6);

    // R3: partial and overlong sleep
    select_dev(); xfer(8'hB9, 4, r); deselect_dev(); wait_clk(10);
    chk("R3 short sleep ignored", int'(in_pd), 0);
    select_dev(); xfer(8'hB9, 8, r); xfer(8'h00, 1, r); deselect_dev(); wait_clk(10);
    chk("R3 long sleep ignored", int'(in_pd), 0);

    // R2: enter deep power-down
    select_dev(); xfer(8'hB9, 8, r); deselect_dev(); wait_clk(10);
    chk("R2 in_pd", int'(in_pd), 1);
    chk("R2 ready low", int'(ready), 0);

    // R4: other opcode in deep
    select_dev(); xfer(8'h9F, 8, r);
    for (int b = 0; b < 4; b++) xfer(8'h00, 8, r);
    chk("R4 no output", int'(so_oe), 0);
    deselect_dev(); wait_clk(10);
    chk("R4 stays deep", int'(in_pd), 1);

    // R9: release cut before the 8th bit
    select_dev(); xfer(8'hAB, 5, r); deselect_dev(); wait_clk(10);
    chk("R9 short release no wake", int'(in_pd), 1);

    // R7: busy blocks release in deep
    busy = 1'b1;
    select_dev(); header(8'hAB); xfer(8'h00, 8, r);
    chk("R7 busy no output", int'(so_oe), 0);
    deselect_dev(); wait_clk(10);
    chk("R7 busy stays deep", int'(in_pd), 1);
    busy = 1'b0;

    // R8: full release from deep with wake-up interval
    select_dev(); header(8'hAB); xfer(8'h00, 8, r);
    chk("R5 signature in deep", int'(r), SIGV);
    deselect_dev(); wait_clk(8);
    chk("R8 waking ready low", int'(ready), 0);
    chk("R8 waking not deep", int'(in_pd), 0);
    wait_clk(TW + 10);
    chk("R8 ready after interval", int'(ready), 1);

    // R9 + R10: release cut after opcode, then selection during wake
    select_dev(); xfer(8'hB9, 8, r); deselect_dev(); wait_clk(10);
    chk("R2 deep again", int'(in_pd), 1);
    select_dev(); xfer(8'hAB, 8, r); deselect_dev(); wait_clk(4);
    chk("R9 opcode-only release wakes", int'(in_pd), 0);
    chk("R9 ready low while waking", int'(ready), 0);
    wait_clk(2);
    select_dev(); xfer(8'hB9, 8, r); deselect_dev(); wait_clk(TW + 20);
    chk("R10 sleep during wake ignored", int'(in_pd), 0);
    chk("R10 ready", int'(ready), 1);

    // R7: busy blocks release in standby
    busy = 1'b1;
    select_dev(); header(8'hAB); xfer(8'h00, 8, r);
    chk("R7 busy standby no output", int'(so_oe), 0);
    deselect_dev(); wait_clk(10);
    busy = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule